// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit linear address into a physical address by reading translation entries from memory. A request carries the linear address and two access attributes: whether it is a write and whether it comes from user mode. With paging switched on, the walker reads one entry from a first-level table (the directory), whose base frame is held in a control register outside the block. Unless that entry maps a large 4 MiB page, it then reads one entry from a second-level table. It returns either a physical address or a fault code together with the level at which the fault was found. With paging switched off, the linear address is returned unchanged and no memory is touched.

The linear address splits, from the top down, into a 10-bit directory index, a 10-bit table index and a 12-bit byte offset. Each entry is one 32-bit word. Bits 31:12 hold a frame number, and flag bits sit at fixed positions. The walker reaches memory through a single word-wide request/acknowledge port that carries one transfer at a time. It also keeps the usage flags in memory up to date: it writes an entry back with its accessed flag set, and on a write access with its dirty flag set, whenever those flags were still clear.

Top module: `ptw_walker`

## Requirements
- R1: When `paging_en_i` is 0, an accepted request produces `rsp_valid_o` in the next cycle, with `rsp_paddr_o` equal to the linear address, no fault, and no memory transfer.
- R2: The first read of a walk goes to byte address {root frame, linear[31:22], 2'b00}. The memory request is held with a stable address and direction until `mem_ack_i` is seen.
- R3: For an entry with flag bit 7 (large page) clear, the second read goes to {directory entry[31:12], linear[21:12], 2'b00}, and the physical address is {table entry[31:12], linear[11:0]}.
- R4: A directory entry with bit 7 set and bit 0 set ends the walk after one read. The physical address is {entry[31:22], linear[21:0]}.
- R5: An entry with bit 0 (present) clear ends the walk at once with `rsp_fault_kind_o` = 1 and `rsp_fault_lvl_o` = 0 for the directory or 1 for the table. `rsp_paddr_o` is 0 and no entry is written.
- R6: A write is allowed only if bit 1 (writable) is set in every entry used. A user access is allowed only if bit 2 (user) is set in every entry used. A violation gives `rsp_fault_kind_o` = 2 at the level of the final entry, and the final entry is not written.
- R7: Each entry used on a successful path whose bit 5 (accessed) is clear is written back to its own address with bit 5 set. If bit 5 is already set and no dirty update is due, no write happens.
- R8: On a write access, the final entry is written back with bit 6 (dirty) and bit 5 both set, in a single transfer, if either was clear.
- R9: `req_ready_o` is 0 from acceptance until the walk ends. A `req_valid_i` seen in that time is ignored.
- R10: `rsp_valid_o` lasts one cycle and coincides with `req_ready_o` = 1, so a new request can be accepted in the same cycle as the previous response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| paging_en_i | input | 1 | 1 = translate, 0 = pass addresses through |
| root_frame_i | input | 20 | Frame number of the directory |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_vaddr_i | input | 32 | Linear address |
| req_write_i | input | 1 | Access is a write |
| req_user_i | input | 1 | Access is from user mode |
| rsp_valid_o | output | 1 | One-cycle result strobe |
| rsp_paddr_o | output | 32 | Physical address (0 on fault) |
| rsp_fault_o | output | 1 | Result is a fault |
| rsp_fault_kind_o | output | 2 | 0 none, 1 not present, 2 protection |
| rsp_fault_lvl_o | output | 1 | 0 directory, 1 table |
| mem_req_o | output | 1 | Memory transfer request |
| mem_we_o | output | 1 | Transfer is a write |
| mem_addr_o | output | 32 | Byte address of the entry |
| mem_wdata_o | output | 32 | Entry written back |
| mem_ack_i | input | 1 | Transfer done; read data valid |
| mem_rdata_i | input | 32 | Entry read |

## Verification
Two events can fall on the same cycle: delivery of a result and acceptance of the next request, because the response strobe is raised in the cycle the walker is idle again. The bench provokes this by presenting a new request at the sampling point where the previous response is seen. It then checks that `req_ready_o` is high in that cycle and that the second walk returns its own correct address. It also pulses a stray request while a walk is in progress and confirms, from the response count and the memory traffic, that the stray request never produced a walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   // flag positions inside a translation entry
   localparam int ENT_P  = 0;
   localparam int ENT_RW = 1;
   localparam int ENT_US = 2;
   localparam int ENT_A  = 5;
   localparam int ENT_D  = 6;
   localparam int ENT_PS = 7;

   typedef enum logic [1:0] {
      FLT_NONE    = 2'd0,
      FLT_NOTPRES = 2'd1,
      FLT_PROT    = 2'd2
   } fault_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DIR_RD,
      ST_DIR_WR,
      ST_TBL_RD,
      ST_TBL_WR
   } walk_state_e;

endpackage

// File: rtl/ptw_entry_eval.sv
module ptw_entry_eval
   import ptw_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter bit SET_AD = 1'b1
) (
   input  logic [WORD_W-1:0] entry_i,
   input  logic              final_i,
   input  logic              want_write_i,
   input  logic              want_user_i,
   input  logic              up_rw_i,
   input  logic              up_us_i,
   output logic              present_o,
   output logic              large_o,
   output logic              perm_ok_o,
   output logic              need_wb_o,
   output logic [WORD_W-1:0] wb_data_o
);

   logic rw_eff, us_eff, set_dirty;

   initial begin
      if (WORD_W <= ENT_PS) $error("entry word too narrow for flag field");
   end

   assign present_o = entry_i[ENT_P];
   assign large_o   = entry_i[ENT_PS];
   assign rw_eff    = up_rw_i & entry_i[ENT_RW];
   assign us_eff    = up_us_i & entry_i[ENT_US];
   assign perm_ok_o = !(want_write_i && !rw_eff) && !(want_user_i && !us_eff);
   assign set_dirty = final_i & want_write_i;

   generate
      if (SET_AD) begin : g_ad_update
         always_comb begin
            wb_data_o         = entry_i;
            wb_data_o[ENT_A]  = 1'b1;
            if (set_dirty) wb_data_o[ENT_D] = 1'b1;
            need_wb_o = !entry_i[ENT_A] || (set_dirty && !entry_i[ENT_D]);
         end
      end else begin : g_ad_none
         assign wb_data_o = entry_i;
         assign need_wb_o = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
   parameter int DIR_IDX_W = 10,
   parameter int TBL_IDX_W = 10,
   parameter int OFF_W     = 12,
   parameter int WORD_W    = 32,
   localparam int VA_W     = DIR_IDX_W + TBL_IDX_W + OFF_W,
   localparam int FRAME_W  = WORD_W - OFF_W,
   localparam int LARGE_W  = WORD_W - TBL_IDX_W - OFF_W,
   localparam int BYTE_SH  = $clog2(WORD_W / 8)
) (
   input  logic [FRAME_W-1:0] root_frame_i,
   input  logic [FRAME_W-1:0] pde_frame_i,
   input  logic [FRAME_W-1:0] leaf_frame_i,
   input  logic [VA_W-1:0]    va_i,
   output logic [WORD_W-1:0]  dir_addr_o,
   output logic [WORD_W-1:0]  tbl_addr_o,
   output logic [WORD_W-1:0]  small_pa_o,
   output logic [WORD_W-1:0]  large_pa_o
);

   logic [DIR_IDX_W-1:0] dir_idx;
   logic [TBL_IDX_W-1:0] tbl_idx;
   logic [OFF_W-1:0]     off;

   initial begin
      if (VA_W != WORD_W)               $error("linear address must fill one word");
      if (DIR_IDX_W + BYTE_SH != OFF_W) $error("directory must fill one frame");
      if (TBL_IDX_W + BYTE_SH != OFF_W) $error("table must fill one frame");
   end

   assign {dir_idx, tbl_idx, off} = va_i;

   assign dir_addr_o = {root_frame_i, dir_idx, {BYTE_SH{1'b0}}};
   assign tbl_addr_o = {pde_frame_i, tbl_idx, {BYTE_SH{1'b0}}};
   assign small_pa_o = {leaf_frame_i, off};
   assign large_pa_o = {leaf_frame_i[FRAME_W-1 -: LARGE_W], tbl_idx, off};

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int DIR_IDX_W = 10,
   parameter int TBL_IDX_W = 10,
   parameter int OFF_W     = 12,
   parameter int WORD_W    = 32,
   parameter bit SET_AD    = 1'b1,
   localparam int VA_W     = DIR_IDX_W + TBL_IDX_W + OFF_W,
   localparam int FRAME_W  = WORD_W - OFF_W
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               paging_en_i,
   input  logic [FRAME_W-1:0] root_frame_i,
   input  logic               req_valid_i,
   output logic               req_ready_o,
   input  logic [VA_W-1:0]    req_vaddr_i,
   input  logic               req_write_i,
   input  logic               req_user_i,
   output logic               rsp_valid_o,
   output logic [WORD_W-1:0]  rsp_paddr_o,
   output logic               rsp_fault_o,
   output logic [1:0]         rsp_fault_kind_o,
   output logic               rsp_fault_lvl_o,
   output logic               mem_req_o,
   output logic               mem_we_o,
   output logic [WORD_W-1:0]  mem_addr_o,
   output logic [WORD_W-1:0]  mem_wdata_o,
   input  logic               mem_ack_i,
   input  logic [WORD_W-1:0]  mem_rdata_i
);

   walk_state_e        state_q, state_d;
   logic [VA_W-1:0]    va_q;
   logic               wr_q, usr_q;
   logic [WORD_W-1:0]  ent_q, ent_d;
   logic [FRAME_W-1:0] pde_frame_q;
   logic               pde_rw_q, pde_us_q;
   logic               grab_pde;

   logic               rsp_valid_q, done_c;
   logic [WORD_W-1:0]  rsp_pa_q, done_pa;
   fault_e             kind_q, done_kind;
   logic               lvl_q, done_lvl;

   logic               in_read;
   logic               ev_final, ev_up_rw, ev_up_us;
   logic               ev_present, ev_large, ev_perm_ok, ev_need_wb;
   logic [WORD_W-1:0]  ev_wb;
   logic [FRAME_W-1:0] leaf_frame;
   logic [WORD_W-1:0]  dir_addr, tbl_addr, small_pa, large_pa;

   // entry evaluation: fed by the word that just arrived
   assign in_read  = (state_q == ST_DIR_RD) || (state_q == ST_TBL_RD);
   assign ev_final = (state_q == ST_DIR_RD) ? mem_rdata_i[ENT_PS] : 1'b1;
   assign ev_up_rw = (state_q == ST_TBL_RD) ? pde_rw_q : 1'b1;
   assign ev_up_us = (state_q == ST_TBL_RD) ? pde_us_q : 1'b1;

   ptw_entry_eval #(
      .WORD_W (WORD_W),
      .SET_AD (SET_AD)
   ) u_eval (
      .entry_i      (mem_rdata_i),
      .final_i      (ev_final),
      .want_write_i (wr_q),
      .want_user_i  (usr_q),
      .up_rw_i      (ev_up_rw),
      .up_us_i      (ev_up_us),
      .present_o    (ev_present),
      .large_o      (ev_large),
      .perm_ok_o    (ev_perm_ok),
      .need_wb_o    (ev_need_wb),
      .wb_data_o    (ev_wb)
   );

   assign leaf_frame = in_read ? mem_rdata_i[WORD_W-1:OFF_W] : ent_q[WORD_W-1:OFF_W];

   ptw_addr_gen #(
      .DIR_IDX_W (DIR_IDX_W),
      .TBL_IDX_W (TBL_IDX_W),
      .OFF_W     (OFF_W),
      .WORD_W    (WORD_W)
   ) u_addr (
      .root_frame_i (root_frame_i),
      .pde_frame_i  (pde_frame_q),
      .leaf_frame_i (leaf_frame),
      .va_i         (va_q),
      .dir_addr_o   (dir_addr),
      .tbl_addr_o   (tbl_addr),
      .small_pa_o   (small_pa),
      .large_pa_o   (large_pa)
   );

   // next-state and result selection
   always_comb begin
      state_d   = state_q;
      ent_d     = ent_q;
      grab_pde  = 1'b0;
      done_c    = 1'b0;
      done_pa   = '0;
      done_kind = FLT_NONE;
      done_lvl  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (req_valid_i) begin
               if (!paging_en_i) begin
                  done_c  = 1'b1;
                  done_pa = req_vaddr_i;
               end else begin
                  state_d = ST_DIR_RD;
               end
            end
         end
         ST_DIR_RD: begin
            if (mem_ack_i) begin
               if (!ev_present) begin
                  done_c    = 1'b1;
                  done_kind = FLT_NOTPRES;
               end else if (ev_large && !ev_perm_ok) begin
                  done_c    = 1'b1;
                  done_kind = FLT_PROT;
               end else begin
                  grab_pde = 1'b1;
                  ent_d    = ev_need_wb ? ev_wb : mem_rdata_i;
                  if (ev_need_wb) begin
                     state_d = ST_DIR_WR;
                  end else if (ev_large) begin
                     done_c  = 1'b1;
                     done_pa = large_pa;
                  end else begin
                     state_d = ST_TBL_RD;
                  end
               end
            end
         end
         ST_DIR_WR: begin
            if (mem_ack_i) begin
               if (ent_q[ENT_PS]) begin
                  done_c  = 1'b1;
                  done_pa = large_pa;
               end else begin
                  state_d = ST_TBL_RD;
               end
            end
         end
         ST_TBL_RD: begin
            if (mem_ack_i) begin
               if (!ev_present) begin
                  done_c    = 1'b1;
                  done_kind = FLT_NOTPRES;
                  done_lvl  = 1'b1;
               end else if (!ev_perm_ok) begin
                  done_c    = 1'b1;
                  done_kind = FLT_PROT;
                  done_lvl  = 1'b1;
               end else begin
                  ent_d = ev_need_wb ? ev_wb : mem_rdata_i;
                  if (ev_need_wb) begin
                     state_d = ST_TBL_WR;
                  end else begin
                     done_c  = 1'b1;
                     done_pa = small_pa;
                  end
               end
            end
         end
         ST_TBL_WR: begin
            if (mem_ack_i) begin
               done_c  = 1'b1;
               done_pa = small_pa;
            end
         end
         default: state_d = ST_IDLE;
      endcase
      if (done_c) state_d = ST_IDLE;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q     <= ST_IDLE;
         va_q        <= '0;
         wr_q        <= 1'b0;
         usr_q       <= 1'b0;
         ent_q       <= '0;
         pde_frame_q <= '0;
         pde_rw_q    <= 1'b0;
         pde_us_q    <= 1'b0;
         rsp_valid_q <= 1'b0;
         rsp_pa_q    <= '0;
         kind_q      <= FLT_NONE;
         lvl_q       <= 1'b0;
      end else begin
         state_q     <= state_d;
         ent_q       <= ent_d;
         rsp_valid_q <= done_c;
         if (state_q == ST_IDLE && req_valid_i) begin
            va_q  <= req_vaddr_i;
            wr_q  <= req_write_i;
            usr_q <= req_user_i;
         end
         if (grab_pde) begin
            pde_frame_q <= mem_rdata_i[WORD_W-1:OFF_W];
            pde_rw_q    <= mem_rdata_i[ENT_RW];
            pde_us_q    <= mem_rdata_i[ENT_US];
         end
         if (done_c) begin
            rsp_pa_q <= done_pa;
            kind_q   <= done_kind;
            lvl_q    <= done_lvl;
         end
      end
   end

   assign req_ready_o      = (state_q == ST_IDLE);
   assign rsp_valid_o      = rsp_valid_q;
   assign rsp_paddr_o      = rsp_pa_q;
   assign rsp_fault_kind_o = kind_q;
   assign rsp_fault_o      = (kind_q != FLT_NONE);
   assign rsp_fault_lvl_o  = lvl_q;

   assign mem_req_o   = (state_q != ST_IDLE);
   assign mem_we_o    = (state_q == ST_DIR_WR) || (state_q == ST_TBL_WR);
   assign mem_addr_o  = (state_q == ST_DIR_RD || state_q == ST_DIR_WR) ? dir_addr : tbl_addr;
   assign mem_wdata_o = ent_q;

   // R1: pass-through answers in the next cycle with the same address
   p_passthru_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && req_ready_o && !paging_en_i) |=>
         (rsp_valid_o && !rsp_fault_o && rsp_paddr_o == $past(req_vaddr_i)));

   // R2: an unacknowledged transfer keeps address and direction
   p_hold_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_req_o && !mem_ack_i) |=>
         (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

   // R5: a faulting result carries no address
   p_fault_pa_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rsp_valid_o && rsp_fault_o) |-> (rsp_paddr_o == '0));

   // R7: every write-back carries the accessed flag
   p_wb_acc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_req_o && mem_we_o) |-> mem_wdata_o[ENT_A]);

   // R9: no new request is taken while memory is in use
   p_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_req_o |-> !req_ready_o);

   // R10: a result is only presented when the walker is idle
   p_rsp_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_valid_o |-> (req_ready_o && !mem_req_o));

endmodule

// File: tb/ptw_walker_bench.sv
`timescale 1ns/1ps
module ptw_walker_bench;

   localparam logic [31:0] F_P = 32'h01, F_RW = 32'h02, F_US = 32'h04;
   localparam logic [31:0] F_A = 32'h20, F_D = 32'h40, F_PS = 32'h80;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        paging_en = 1'b0;
   logic [19:0] root_frame = 20'h00001;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic        req_user = 1'b0;
   logic        rsp_valid, rsp_fault, rsp_lvl;
   logic [31:0] rsp_paddr;
   logic [1:0]  rsp_kind;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;

   logic [31:0] mem [0:4095];
   logic [31:0] rd_log [0:255];
   int          rd_cnt = 0, wr_cnt = 0, rsp_cnt = 0;
   int          checks = 0, errors = 0;

   always #2.5 clk = ~clk;

   ptw_walker u_ptw_walker (
      .clk_i            (clk),
      .rst_ni           (rst_n),
      .paging_en_i      (paging_en),
      .root_frame_i     (root_frame),
      .req_valid_i      (req_valid),
      .req_ready_o      (req_ready),
      .req_vaddr_i      (req_vaddr),
      .req_write_i      (req_write),
      .req_user_i       (req_user),
      .rsp_valid_o      (rsp_valid),
      .rsp_paddr_o      (rsp_paddr),
      .rsp_fault_o      (rsp_fault),
      .rsp_fault_kind_o (rsp_kind),
      .rsp_fault_lvl_o  (rsp_lvl),
      .mem_req_o        (mem_req),
      .mem_we_o         (mem_we),
      .mem_addr_o       (mem_addr),
      .mem_wdata_o      (mem_wdata),
      .mem_ack_i        (mem_ack),
      .mem_rdata_i      (mem_rdata)
   );

   // memory model: acknowledges one cycle after a request is seen
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0;
      end else if (mem_req && !mem_ack) begin
         mem_ack <= 1'b1;
         if (mem_we) begin
            mem[mem_addr[13:2]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
         end else begin
            mem_rdata <= mem[mem_addr[13:2]];
            rd_log[rd_cnt[7:0]] <= mem_addr;
            rd_cnt <= rd_cnt + 1;
         end
      end else begin
         mem_ack <= 1'b0;
      end
      if (rst_n && rsp_valid) rsp_cnt <= rsp_cnt + 1;
   end

   function automatic logic [31:0] va(input int d, input int t, input int o);
      return (32'(d) << 22) | (32'(t) << 12) | 32'(o);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   // one translation; returns results and traffic deltas
   task automatic walk(input logic [31:0] a, input logic w, input logic u,
                       output logic [31:0] pa, output logic [1:0] kind, output logic lvl,
                       output int lat, output int rds, output int wrs, output int rd0);
      int r0, w0, n;
      @(negedge clk);
      r0 = rd_cnt; w0 = wr_cnt; rd0 = r0;
      req_vaddr = a; req_write = w; req_user = u; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      n = 0;
      while (!rsp_valid && n < 60) begin
         @(negedge clk);
         n++;
      end
      pa = rsp_paddr; kind = rsp_kind; lvl = rsp_lvl; lat = n;
      rds = rd_cnt - r0; wrs = wr_cnt - w0;
   endtask

   logic [31:0] pa;
   logic [1:0]  kind;
   logic        lvl;
   int          lat, rds, wrs, rd0;

   task automatic t_reset();
      chk("R9 ready after reset", 32'(req_ready), 32'd1);
      chk("R10 no response after reset", 32'(rsp_valid), 32'd0);
      chk("R2 no memory request after reset", 32'(mem_req), 32'd0);
   endtask

   task automatic t_passthru();
      paging_en = 1'b0;
      walk(32'h1234_5678, 1'b1, 1'b1, pa, kind, lvl, lat, rds, wrs, rd0);
      chk("R1 pass-through address", pa, 32'h1234_5678);
      chk("R1 pass-through latency", 32'(lat), 32'd0);
      chk("R1 pass-through no reads", 32'(rds + wrs), 32'd0);
      paging_en = 1'b1;
   endtask

   task automatic t_small_page();
      walk(va(3, 5, 12'hABC), 1'b0, 1'b0, pa, kind, lvl, lat, rds, wrs, rd0);
      chk("R3 small page address", pa, 32'h5555_5ABC);
      chk("R3 small page kind", 32'(kind), 32'd0);
      chk("R2 directory read address", rd_log[rd0[7:0]], 32'h0000_100C);
      chk("R3 table read address", rd_log[rd0[7:0] + 8'd1], 32'h0000_2014);
      chk("R7 no write when accessed already set", 32'(wrs), 32'd0);
   endtask

   task automatic t_large_page();
      walk(32'h01C1_2345, 1'b0, 1'b1, pa, kind, lvl, lat, rds, wrs, rd0);
      chk("R4 large page address", pa, 32'hC041_2345);
      chk("R4 large page single read", 32'(rds), 32'd1);
   endtask

   task automatic t_not_present();
      walk(va(9, 0, 0), 1'b0, 1'b0, pa, kind, lvl, lat, rds, wrs, rd0);
      chk("R5 directory not present kind", 32'(kind), 32'd1);
      chk("R5 directory not present level", 32'(lvl), 32'd0);
      chk("R5 directory fault address", pa, 32'd0);
      chk("R5 directory fault one read", 32'(rds), 32'd1);
      walk(va(3, 6, 12'h010), 1'b0, 1'b0, pa, kind, lvl, lat, rds, wrs, rd0);
      chk("R5 table not present kind", 32'(kind), 32'd1);
      chk("R5 table not present level", 32'(lvl), 32'd1);
      chk("R5 table fault no write", 32'(wrs), 32'd0);
   endtask

   task automatic t_accessed();
      walk(va(4, 8, 12'h044), 1'b0, 1'b0, pa, kind, lvl, lat, rds, wrs, rd0);
      chk("R7 address with write-backs", pa, 32'h7777_7044);
      chk("R7 two write-backs", 32'(wrs), 32'd2);
      chk("R7 directory accessed set", mem[12'h404], 32'h0000_2027);
      chk("R7 table accessed set, dirty clear", mem[12'h808], 32'h7777_7027);
   endtask

   task automatic t_dirty();
      walk(va(4, 8, 12'h044), 1'b1, 1'b0, pa, kind, lvl, lat, rds, wrs, rd0);
      chk("R8 write address", pa, 32'h7777_7044);
      chk("R8 single write-back", 32'(wrs), 32'd1);
      chk("R8 dirty set in table entry", mem[12'h808], 32'h7777_7067);
   endtask

   task automatic t_protect();
      walk(va(3, 10, 0), 1'b1, 1'b0, pa, kind, lvl, lat, rds, wrs, rd0);
      chk("R6 read-only write kind", 32'(kind), 32'd2);
      chk("R6 read-only write level", 32'(lvl), 32'd1);
      chk("R6 read-only entry untouched", mem[12'h80A], 32'h1111_1025);
      walk(va(5, 5, 0), 1'b0, 1'b1, pa, kind, lvl, lat, rds, wrs, rd0);
      chk("R6 user blocked by directory", 32'(kind), 32'd2);
      chk("R6 user fault at final level", 32'(lvl), 32'd1);
      walk(va(8, 0, 0), 1'b1, 1'b0, pa, kind, lvl, lat, rds, wrs, rd0);
      chk("R6 large page write kind", 32'(kind), 32'd2);
      chk("R6 large page write level", 32'(lvl), 32'd0);
      chk("R6 large page no write-back", 32'(wrs), 32'd0);
   endtask

   task automatic t_busy();
      int r0, c0, n;
      @(negedge clk);
      r0 = rd_cnt; c0 = rsp_cnt;
      req_vaddr = va(3, 5, 12'hABC); req_write = 1'b0; req_user = 1'b0; req_valid = 1'b1;
      @(negedge clk);
      chk("R9 ready low during walk", 32'(req_ready), 32'd0);
      req_vaddr = va(9, 0, 0);
      @(negedge clk);
      req_valid = 1'b0;
      n = 0;
      while (!rsp_valid && n < 60) begin
         @(negedge clk);
         n++;
      end
      chk("R9 first request result", rsp_paddr, 32'h5555_5ABC);
      repeat (12) @(negedge clk);
      chk("R9 stray request gave no response", 32'(rsp_cnt - c0), 32'd1);
      chk("R9 stray request gave no reads", 32'(rd_cnt - r0), 32'd2);
   endtask

   task automatic t_back_to_back();
      int n;
      @(negedge clk);
      req_vaddr = 32'h01C1_2345; req_write = 1'b0; req_user = 1'b0; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      n = 0;
      while (!rsp_valid && n < 60) begin
         @(negedge clk);
         n++;
      end
      chk("R10 first result", rsp_paddr, 32'hC041_2345);
      chk("R10 ready during response", 32'(req_ready), 32'd1);
      req_vaddr = va(3, 5, 12'h123); req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R10 response is one cycle", 32'(rsp_valid), 32'd0);
      n = 0;
      while (!rsp_valid && n < 60) begin
         @(negedge clk);
         n++;
      end
      chk("R10 second result", rsp_paddr, 32'h5555_5123);
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = '0;
      mem[12'h403] = 32'h0000_2000 | F_P | F_RW | F_US | F_A;          // dir 3
      mem[12'h805] = 32'h5555_5000 | F_P | F_RW | F_US | F_A | F_D;    // tbl 5
      mem[12'h407] = 32'hC040_0000 | F_P | F_RW | F_US | F_A | F_PS;   // dir 7 large
      mem[12'h404] = 32'h0000_2000 | F_P | F_RW | F_US;                // dir 4, A clear
      mem[12'h808] = 32'h7777_7000 | F_P | F_RW | F_US;                // tbl 8, A clear
      mem[12'h80A] = 32'h1111_1000 | F_P | F_US | F_A;                 // tbl 10 read-only
      mem[12'h405] = 32'h0000_2000 | F_P | F_RW | F_A;                 // dir 5 supervisor
      mem[12'h408] = 32'h4000_0000 | F_P | F_A | F_PS;                 // dir 8 large, RO
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_passthru();
      t_small_page();
      t_large_page();
      t_not_present();
      t_accessed();
      t_dirty();
      t_protect();
      t_busy();
      t_back_to_back();
      repeat (4) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(5ns * 20000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule